// File: doc/BRIEF.md
# Dual-Rate Word Serializer

This block turns a parallel word into a serial stream, least significant bit first. A static mode input picks one of two rates. At full rate one bit leaves per clock on lane bit 0. At double rate two bits leave per clock on a 2-bit lane, so the whole design runs on one rising-edge clock. A word-frame output marks the first half of each word as it leaves, and upstream logic can use it as the cue to present the next word.

An active-low asynchronous reset clears every register at once. Its release passes through a two-stage synchronizer, so the first capture always lands on a fixed edge and no partial word is sent. A hold input is registered once and then freezes the whole pipeline. While the hold is in force the outputs read zero. When it is released the stream carries on from the exact bit where it stopped. Latency from capture to first output is fixed per mode, and the mode input may only change while reset is asserted.

Top module: `dual_rate_serializer`

## Requirements
- R1: The bits of each captured word leave in ascending index order: bit 0 first, bit 7 last.
- R2: With `full_rate_i`=1, one bit leaves per clock on `lane_o[0]`, `lane_o[1]` stays 0, and a new word is captured every 8 active clocks.
- R3: With `full_rate_i`=0, two bits leave per clock, the earlier one on `lane_o[0]` and the later one on `lane_o[1]`, and a new word is captured every 4 active clocks.
- R4: At double rate, the first bits of a word are visible after the 7th active edge that follows its capture edge.
- R5: At full rate, the first bit of a word is visible after the 14th active edge that follows its capture edge.
- R6: `frame_o` is high while the first half of a word is on the lane: 4 clocks of every 8 at full rate, and 2 clocks of every 4 at double rate.
- R7: Driving `rst_n` low forces `lane_o`, `lane_vld_o` and `frame_o` to 0 at once, without waiting for a clock edge.
- R8: After `rst_n` rises, the first two edges only arm the block. At double rate the first word is captured on edge 3. At full rate it is captured on edge 4. So the first valid output follows edge 10 or edge 18 respectively.
- R9: `hold_i` is sampled on each edge. In the cycle after it is seen high, all outputs are 0 and no state moves. The stream resumes with the next undelivered bit once a low sample is taken.
- R10: `lane_vld_o` is high in every cycle that is neither held nor in reset, from the first delivered bits onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| full_rate_i | input | 1 | 1 = one bit per clock, 0 = two bits per clock; static outside reset |
| hold_i | input | 1 | Pause request, registered before use |
| word_i | input | WORD_W | Parallel word, sampled on capture edges |
| lane_o | output | 2 | Serial lane; bit 0 is the earlier bit |
| lane_vld_o | output | 1 | Lane carries fresh serial data this cycle |
| frame_o | output | 1 | High during the first half of each word on the lane |

## Verification
A hold can land on the same edge as a word capture or a word boundary. The stimulus puts random hold runs over a stream whose capture edges fall every 4 or 8 active clocks, so pauses collide with captures, with the half-word frame edge, and with the edge that arms the block. The bench keeps its own count of active edges and compares every output cycle with the word it recorded at the matching capture index. A pause that drops, repeats or shifts a bit therefore appears as a lane or frame mismatch. A reset in the middle of a stream is also checked straight after the asynchronous assertion and again across the re-arm sequence.

// File: rtl/dser_pkg.sv
package dser_pkg;
  // One output beat as it travels through the latency line.
  typedef struct packed {
    logic       frame;
    logic       vld;
    logic [1:0] lane;
  } dser_beat_t;
endpackage

// File: rtl/dser_rst_sync.sv
module dser_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic arm_o
);
  logic s1_q, s2_q;
  logic s1_d, s2_d;

  always_comb begin
    s1_d = 1'b1;
    s2_d = s1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end

  assign arm_o = s2_q;
endmodule

// File: rtl/dser_shift.sv
module dser_shift
  import dser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              dbl_i,
  input  logic [WORD_W-1:0] word_i,
  output dser_beat_t        beat_o
);
  localparam int SLOT_W = $clog2(WORD_W);
  localparam logic [SLOT_W-1:0] LAST_FULL = SLOT_W'(WORD_W - 1);
  localparam logic [SLOT_W-1:0] LAST_DBL  = SLOT_W'(WORD_W / 2 - 1);
  localparam logic [SLOT_W-1:0] HALF_FULL = SLOT_W'(WORD_W / 2);
  localparam logic [SLOT_W-1:0] HALF_DBL  = SLOT_W'(WORD_W / 4);

  logic              primed_q, primed_d;
  logic              started_q, started_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic [SLOT_W-1:0] last, half;

  assign last = dbl_i ? LAST_DBL : LAST_FULL;
  assign half = dbl_i ? HALF_DBL : HALF_FULL;

  // Slot 0 is a capture slot; the full-rate path waits one primed step first.
  always_comb begin
    primed_d  = primed_q;
    started_d = started_q;
    slot_d    = slot_q;
    sh_d      = sh_q;
    if (step_i) begin
      primed_d = 1'b1;
      if (dbl_i || primed_q) begin
        if (slot_q == '0) begin
          sh_d      = word_i;
          started_d = 1'b1;
        end else if (dbl_i) begin
          sh_d = sh_q >> 2;
        end else begin
          sh_d = sh_q >> 1;
        end
        slot_d = (slot_q == last) ? '0 : slot_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      started_q <= 1'b0;
      slot_q    <= '0;
      sh_q      <= '0;
    end else begin
      primed_q  <= primed_d;
      started_q <= started_d;
      slot_q    <= slot_d;
      sh_q      <= sh_d;
    end
  end

  always_comb begin
    beat_o.vld   = started_q;
    beat_o.lane  = '0;
    beat_o.frame = started_q && (slot_q != '0) && (slot_q <= half);
    if (started_q) begin
      beat_o.lane = dbl_i ? sh_q[1:0] : {1'b0, sh_q[0]};
    end
  end
endmodule

// File: rtl/dser_dly.sv
module dser_dly #(
  parameter int W     = 4,
  parameter int DEPTH = 14,
  parameter int TAP_A = 7,
  parameter int TAP_B = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         sel_b_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [DEPTH-1:0][W-1:0] stg_q;
  logic [DEPTH-1:0][W-1:0] stg_d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      if (i == 0) begin : g_head
        assign stg_d[i] = d_i;
      end else begin : g_body
        assign stg_d[i] = stg_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (en_i) begin
      stg_q <= stg_d;
    end
  end

  assign q_o = sel_b_i ? stg_q[TAP_B-1] : stg_q[TAP_A-1];
endmodule

// File: rtl/dual_rate_serializer.sv
module dual_rate_serializer
  import dser_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LAT_DBL  = 7,
  parameter int LAT_FULL = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_rate_i,
  input  logic              hold_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        lane_o,
  output logic              lane_vld_o,
  output logic              frame_o
);
  localparam int DEPTH  = (LAT_FULL > LAT_DBL) ? LAT_FULL : LAT_DBL;
  localparam int BEAT_W = $bits(dser_beat_t);

  logic              arm;
  logic              hold_q, hold_d;
  logic              active;
  dser_beat_t        raw_b, tap_b, out_b;
  logic [BEAT_W-1:0] tap_v;

  dser_rst_sync u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .arm_o (arm)
  );

  assign hold_d = hold_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign active = arm & ~hold_q;

  dser_shift #(.WORD_W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (active),
    .dbl_i  (~full_rate_i),
    .word_i (word_i),
    .beat_o (raw_b)
  );

  dser_dly #(
    .W     (BEAT_W),
    .DEPTH (DEPTH),
    .TAP_A (LAT_DBL),
    .TAP_B (LAT_FULL)
  ) u_dly (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (active),
    .sel_b_i (full_rate_i),
    .d_i     (raw_b),
    .q_o     (tap_v)
  );

  assign tap_b = dser_beat_t'(tap_v);
  assign out_b = active ? tap_b : '0;

  assign lane_o     = out_b.lane;
  assign lane_vld_o = out_b.vld;
  assign frame_o    = out_b.frame;
endmodule

// File: rtl/dser_chk.sv
module dser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       full_rate_i,
  input logic       hold_i,
  input logic [1:0] lane_o,
  input logic       lane_vld_o,
  input logic       frame_o
);
  a_r7_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (lane_o == 2'b00 && !lane_vld_o && !frame_o));

  a_r9_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hold_i) |-> (lane_o == 2'b00 && !lane_vld_o && !frame_o));

  a_r2_single_lane: assert property (@(posedge clk) disable iff (!rst_n)
    full_rate_i |-> (lane_o[1] == 1'b0));

  a_r6_frame_in_word: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |-> lane_vld_o);

  a_r10_vld_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_vld_o && !hold_i) |=> lane_vld_o);
endmodule

bind dual_rate_serializer dser_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .full_rate_i (full_rate_i),
  .hold_i      (hold_i),
  .lane_o      (lane_o),
  .lane_vld_o  (lane_vld_o),
  .frame_o     (frame_o)
);

// File: tb/dual_rate_serializer_bench.sv
`timescale 1ns/1ps
module dual_rate_serializer_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       full_rate_i;
  logic       hold_i;
  logic [7:0] word_i;
  logic [1:0] lane_o;
  logic       lane_vld_o;
  logic       frame_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [7:0] words [0:2047];
  bit  in_rst;
  int  arm_cnt;
  bit  hq;
  int  act;
  int  since_rel;
  int  first_vld;

  always #10 clk = ~clk;

  dual_rate_serializer u_dual_rate_serializer (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_rate_i (full_rate_i),
    .hold_i      (hold_i),
    .word_i      (word_i),
    .lane_o      (lane_o),
    .lane_vld_o  (lane_vld_o),
    .frame_o     (frame_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // {frame, vld, lane[1:0]} after a given count of active edges
  function automatic logic [3:0] exp_beat(input int a, input bit full);
    int s, lat, n, k, c, p;
    logic [7:0] w;
    logic [1:0] ln;
    s = full ? 2 : 1;
    lat = full ? 14 : 7;
    n = full ? 8 : 4;
    k = a - lat - s;
    if (k < 0) return 4'b0000;
    c = s + (k / n) * n;
    p = k % n;
    w = words[c];
    ln = full ? {1'b0, w[p]} : {w[2*p+1], w[2*p]};
    return {(p < n/2), 1'b1, ln};
  endfunction

  // Drive at a negedge, model the next posedge, check at the following negedge.
  task automatic cyc(input bit h, input logic [7:0] w);
    logic [3:0] e;
    bit quiet;
    hold_i = h;
    word_i = w;
    if (!in_rst) begin
      if (arm_cnt >= 2 && !hq) begin
        act++;
        words[act] = w;
      end
      arm_cnt++;
      since_rel++;
      hq = h;
    end
    @(posedge clk);
    @(negedge clk);
    quiet = in_rst || arm_cnt < 2 || hq;
    e = quiet ? 4'b0000 : exp_beat(act, full_rate_i);
    if (quiet && !in_rst && hq) begin
      check("R9 lane", lane_o, 0);
      check("R9 vld", lane_vld_o, 0);
      check("R9 frame", frame_o, 0);
    end else begin
      check(full_rate_i ? "R1 R2 lane" : "R1 R3 lane", lane_o, e[1:0]);
      check("R10 vld", lane_vld_o, e[2]);
      check("R6 frame", frame_o, e[3]);
    end
    if (lane_vld_o && first_vld < 0) first_vld = since_rel;
  endtask

  task automatic do_reset(input bit full);
    rst_n = 1'b0;
    in_rst = 1'b1;
    hq = 1'b0;
    #1;
    check("R7 lane", lane_o, 0);
    check("R7 vld", lane_vld_o, 0);
    check("R7 frame", frame_o, 0);
    full_rate_i = full;
    @(negedge clk);
    cyc(1'b0, 8'h00);
    cyc(1'b1, 8'hFF);
    rst_n = 1'b1;
    in_rst = 1'b0;
    arm_cnt = 0;
    act = 0;
    since_rel = 0;
    first_vld = -1;
  endtask

  task automatic directed(input bit full);
    do_reset(full);
    cyc(1'b0, 8'h01);
    cyc(1'b0, 8'h01);
    cyc(1'b0, 8'h01);
    cyc(1'b0, 8'h01);
    for (int i = 0; i < 40; i++) cyc(1'b0, 8'(i * 37 + 5));
    check("R8 first valid edge", first_vld, full ? 18 : 10);
    if (full) check("R5 latency", first_vld - 4, 14);
    else      check("R4 latency", first_vld - 3, 7);
  endtask

  task automatic random_run(input bit full, input int len);
    bit h;
    int run;
    h = 1'b0;
    run = 0;
    for (int i = 0; i < len; i++) begin
      if (run == 0) begin
        h = ($urandom_range(0, 5) == 0);
        run = h ? $urandom_range(1, 4) : $urandom_range(1, 12);
      end
      run--;
      cyc(h, 8'($urandom));
      if (i == len / 2) begin
        do_reset(full);
        h = 1'b0;
        run = 0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    full_rate_i = 1'b1;
    hold_i = 1'b0;
    word_i = 8'h00;
    in_rst = 1'b1;
    arm_cnt = 0;
    hq = 1'b0;
    act = 0;
    since_rel = 0;
    first_vld = -1;
    @(negedge clk);
    check("R7 reset lane", lane_o, 0);
    check("R7 reset vld", lane_vld_o, 0);
    directed(1'b1);
    directed(1'b0);
    // hold landing right on the arming edges
    do_reset(1'b0);
    cyc(1'b1, 8'hA5);
    cyc(1'b0, 8'h3C);
    cyc(1'b1, 8'h96);
    for (int i = 0; i < 30; i++) cyc(i % 5 == 0, 8'($urandom));
    random_run(1'b1, 1200);
    random_run(1'b0, 1200);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule